// File: doc/BRIEF.md
# Peripheral Register Window Access Decoder

This block sits between a CPU data port and the peripheral register slaves of a chip. It watches the top 32 KiB of a 24-bit address space. It takes byte, word and longword requests and breaks each one into up to four consecutive byte lanes, starting at the base address. Each lane is looked up in a classification table and marked as one of four kinds: a mapped register, a hole that reads all-ones, a hole that reads all-zeros, or a bus-error location. Mapped lanes are handed to the register slaves through per-lane strobes, offsets and data. Holes absorb writes.

The block answers every request one cycle later with a valid strobe, the assembled read data and a single fault flag. The fault flag is raised in two cases. The first is an access outside the window or from user mode. The second is an access in which every lane lands on a bus-error location. Because of this, a wide access that partly overlaps live registers completes normally.

A 252-byte alias region repeats the four sound-chip registers. The full 32-bit address and the direction of the most recent faulting access are held for exception reporting. The classification table works per granule of 2^GRAN_LOG2 bytes. It is written through a configuration port and comes out of reset marking every granule as a bus error.

Top module: `perio_decoder`

## Requirements
- R1: After reset `rsp_valid` is low and every granule is classified as bus error, so a byte read of any window address faults until the table is written.
- R2: Only address bits 23:0 are decoded. An access whose 24-bit address is below 0xFF8000, or any access with `req_super` low, faults and strobes no lane.
- R3: Size code 0, 1 and 2 selects 1, 2 and 4 lanes (code 3 acts as 2). Lane i covers base+i. Data is big-endian: the base lane holds the most significant byte of the right-justified `req_wdata`/`rsp_rdata`, and unused upper read bits are zero.
- R4: A window access faults only when all of its lanes hit bus-error granules. When it does not fault, a bus-error lane reads 0xFF.
- R5: Class codes are 2'b00 bus error, 2'b01 mapped, 2'b10 hole reading 0xFF and 2'b11 hole reading 0x00. Hole lanes never strobe, so writes to them have no effect.
- R6: A lane address from 0xFF8804 to 0xFF88FF is replaced by that address ANDed with 0xFFF803. Both the table lookup and the lane offset on `lane_addr` use the replaced address.
- R7: A word at base 0xFFFFFF, or a long at a base above 0xFFFFFC, strobes no lane and responds without fault and with all-ones read data.
- R8: A mapped lane strobes only if it is the base lane or if its granule differs from the previous lane's granule. Several lanes in one register granule therefore produce a single strobe.
- R9: On a faulting response, `flt_addr` holds the full 32-bit request address and `flt_write` holds its direction. Both keep their values until the next fault.
- R10: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and `rsp_fault` is never high without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Full request address |
| req_size | input | 2 | 0 byte, 1 word, 2 long |
| req_write | input | 1 | 1 for write |
| req_super | input | 1 | Supervisor mode |
| req_wdata | input | 32 | Write data, right-justified |
| lane_stb | output | 4 | Per-lane register strobe |
| lane_we | output | 1 | Write direction for strobed lanes |
| lane_addr | output | 4*WIN_LOG2 | Per-lane window offset after aliasing |
| lane_wdata | output | 32 | Per-lane write byte, lane i at bits 8i+7:8i |
| lane_rdata | input | 32 | Per-lane read byte from the slaves, same packing |
| cfg_we | input | 1 | Classification table write |
| cfg_idx | input | WIN_LOG2-GRAN_LOG2 | Granule index |
| cfg_class | input | 2 | Class code for the granule |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Access fault |
| rsp_rdata | output | 32 | Read data, right-justified |
| flt_addr | output | 32 | Address of the last faulting access |
| flt_write | output | 1 | Direction of the last faulting access |

## Verification
The bound checker checks the properties that hold on every cycle. These are the one-cycle response timing, that a fault always comes with a valid response, that out-of-window and user-mode requests fault without strobes, that illegal top-of-space requests neither strobe nor fault, and that the fault latch captures the address and then holds it. The directed scenarios are the only place where the table-dependent behaviour is shown. This covers the all-lanes fault rule on straddling accesses, the filler bytes for holes and partly erroring reads, big-endian lane order, alias folding into the sound registers, and the single strobe per granule.

// File: rtl/perio_decoder.sv
module perio_decoder #(
  parameter int ADDR_W    = 24,
  parameter int WIN_LOG2  = 15,
  parameter int GRAN_LOG2 = 4,
  parameter logic [ADDR_W-1:0] MIR_LO   = 'hFF8804,
  parameter logic [ADDR_W-1:0] MIR_HI   = 'hFF88FF,
  parameter logic [ADDR_W-1:0] MIR_MASK = 'hFFF803
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [31:0]                    req_addr,
  input  logic [1:0]                     req_size,
  input  logic                           req_write,
  input  logic                           req_super,
  input  logic [31:0]                    req_wdata,
  output logic [3:0]                     lane_stb,
  output logic                           lane_we,
  output logic [4*WIN_LOG2-1:0]          lane_addr,
  output logic [31:0]                    lane_wdata,
  input  logic [31:0]                    lane_rdata,
  input  logic                           cfg_we,
  input  logic [WIN_LOG2-GRAN_LOG2-1:0]  cfg_idx,
  input  logic [1:0]                     cfg_class,
  output logic                           rsp_valid,
  output logic                           rsp_fault,
  output logic [31:0]                    rsp_rdata,
  output logic [31:0]                    flt_addr,
  output logic                           flt_write
);
  localparam int GIDX_W = WIN_LOG2 - GRAN_LOG2;
  localparam int NGRAN  = 1 << GIDX_W;
  localparam logic [ADDR_W-1:0] TOP = '1;
  localparam logic [1:0] C_BERR = 2'b00, C_MAP = 2'b01, C_HOLE0 = 2'b11;

  logic [1:0] cls_tab [NGRAN];

  logic [ADDR_W-1:0] base;
  logic [2:0]  nlanes;
  logic [5:0]  shamt;
  logic        in_win, priv_fault, illegal, tab_fault, fault, dispatch;
  logic [3:0]  act_v, berr_v, map_v, new_v;
  logic [31:0] wd_left, rd_left, rd_right;

  assign base       = req_addr[ADDR_W-1:0];
  assign in_win     = &base[ADDR_W-1:WIN_LOG2];
  assign priv_fault = !in_win || !req_super;
  assign nlanes     = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd2) ? 3'd4 : 3'd2;
  assign shamt      = {3'd4 - nlanes, 3'b000};
  assign illegal    = (nlanes == 3'd2 && base > TOP - 1) || (nlanes == 3'd4 && base > TOP - 3);
  assign tab_fault  = (berr_v == act_v);
  assign fault      = priv_fault || (!illegal && tab_fault);
  assign dispatch   = req_valid && !priv_fault && !illegal && !tab_fault;
  assign wd_left    = req_wdata << shamt;
  assign rd_right   = rd_left >> shamt;
  assign lane_we    = req_write;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic [ADDR_W-1:0]   raw;
    logic [WIN_LOG2-1:0] off;
    logic [GIDX_W-1:0]   gidx;
    logic [1:0]          cls;

    assign raw  = base + ADDR_W'(i);
    assign off  = (raw >= MIR_LO && raw <= MIR_HI) ? (raw[WIN_LOG2-1:0] & MIR_MASK[WIN_LOG2-1:0])
                                                   : raw[WIN_LOG2-1:0];
    assign gidx = off[WIN_LOG2-1:GRAN_LOG2];
    assign cls  = cls_tab[gidx];

    assign act_v[i]  = (3'(i) < nlanes);
    assign berr_v[i] = act_v[i] && (cls == C_BERR);
    assign map_v[i]  = act_v[i] && (cls == C_MAP);

    if (i == 0) begin : g_first
      assign new_v[i] = 1'b1;
    end else begin : g_next
      assign new_v[i] = (gidx != g_lane[i-1].gidx);
    end

    assign lane_stb[i]                     = dispatch && map_v[i] && new_v[i];
    assign lane_addr[i*WIN_LOG2 +: WIN_LOG2] = off;
    assign lane_wdata[i*8 +: 8]            = wd_left[31-8*i -: 8];
    assign rd_left[31-8*i -: 8]            = (cls == C_MAP)   ? lane_rdata[i*8 +: 8] :
                                             (cls == C_HOLE0) ? 8'h00 : 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NGRAN; g++) cls_tab[g] <= C_BERR;
    end else if (cfg_we) begin
      cls_tab[cfg_idx] <= cfg_class;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
      flt_addr  <= '0;
      flt_write <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && fault;
      if (req_valid) rsp_rdata <= illegal ? ({32{1'b1}} >> shamt) : rd_right;
      if (req_valid && fault) begin
        flt_addr  <= req_addr;
        flt_write <= req_write;
      end
    end
  end
endmodule

// File: rtl/perio_decoder_chk.sv
module perio_decoder_chk #(
  parameter int ADDR_W = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic [1:0]  req_size,
  input logic        req_write,
  input logic        req_super,
  input logic [3:0]  lane_stb,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] flt_addr,
  input logic        flt_write
);
  logic out_win, word_top;
  assign out_win  = !(&req_addr[ADDR_W-1:15]);
  assign word_top = (req_size == 2'd1) && (&req_addr[ADDR_W-1:0]);

  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r10_fault_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid);
  a_r2_outside_faults: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && out_win |=> rsp_fault);
  a_r2_user_faults: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_super |=> rsp_fault);
  a_r2_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (out_win || !req_super) |-> lane_stb == 4'b0000);
  a_r5_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> lane_stb == 4'b0000);
  a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_super && word_top |-> lane_stb == 4'b0000);
  a_r7_illegal_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_super && word_top |=> !rsp_fault);
  a_r9_latch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_super |=> (flt_addr == $past(req_addr)) && (flt_write == $past(req_write)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> $stable(flt_addr) && $stable(flt_write));
endmodule

bind perio_decoder perio_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_size(req_size), .req_write(req_write), .req_super(req_super),
  .lane_stb(lane_stb), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .flt_addr(flt_addr), .flt_write(flt_write)
);

// File: tb/perio_decoder_tb_top.sv
module perio_decoder_tb_top;
  localparam int WL = 15;
  localparam int GW = 11;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_super = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [1:0]  req_size = 0;
  logic [3:0]  lane_stb;
  logic        lane_we;
  logic [4*WL-1:0] lane_addr;
  logic [31:0] lane_wdata, lane_rdata;
  logic        cfg_we = 0;
  logic [GW-1:0] cfg_idx = 0;
  logic [1:0]  cfg_class = 0;
  logic        rsp_valid, rsp_fault, flt_write;
  logic [31:0] rsp_rdata, flt_addr;

  int checks = 0, errors = 0;
  logic [3:0]  s_stb;
  logic [WL-1:0] s_addr0;
  logic [31:0] s_wdata;
  logic        s_we;

  always #5 clk = ~clk;

  perio_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_super(req_super),
    .req_wdata(req_wdata), .lane_stb(lane_stb), .lane_we(lane_we),
    .lane_addr(lane_addr), .lane_wdata(lane_wdata), .lane_rdata(lane_rdata),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_class(cfg_class),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
    .flt_addr(flt_addr), .flt_write(flt_write)
  );

  function automatic logic [7:0] fv(input logic [WL-1:0] o);
    return o[7:0] ^ 8'h5A;
  endfunction

  always_comb
    for (int i = 0; i < 4; i++) lane_rdata[i*8 +: 8] = fv(lane_addr[i*WL +: WL]);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic sup, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_write = wr; req_super = sup; req_wdata = wd;
    #1;
    s_stb = lane_stb; s_addr0 = lane_addr[WL-1:0]; s_wdata = lane_wdata; s_we = lane_we;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic set_class(input logic [GW-1:0] g, input logic [1:0] c);
    @(negedge clk);
    cfg_we = 1; cfg_idx = g; cfg_class = c;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 0);
    access(32'h00FF8100, 2'd0, 0, 1, 0);
    chk("R1 default class faults", {31'b0, rsp_fault}, 1);
    chk("R1 default no strobe", {28'b0, s_stb}, 0);
  endtask

  task automatic t_config;
    set_class(11'h010, 2'b01);
    set_class(11'h012, 2'b10);
    set_class(11'h013, 2'b11);
    set_class(11'h014, 2'b01);
    set_class(11'h015, 2'b01);
    set_class(11'h080, 2'b01);
    set_class(11'h7FF, 2'b01);
  endtask

  task automatic t_privilege;
    access(32'h00001000, 2'd0, 0, 1, 0);
    chk("R2 below window faults", {31'b0, rsp_fault}, 1);
    access(32'h00FF8100, 2'd1, 0, 0, 0);
    chk("R2 user mode faults", {31'b0, rsp_fault}, 1);
    chk("R2 user mode no strobe", {28'b0, s_stb}, 0);
    access(32'hABFF8100, 2'd0, 0, 1, 0);
    chk("R2 upper bits ignored fault", {31'b0, rsp_fault}, 0);
    chk("R2 upper bits ignored data", rsp_rdata, {24'b0, fv(15'h100)});
  endtask

  task automatic t_lanes;
    access(32'h00FF8100, 2'd1, 0, 1, 0);
    chk("R3 word read", rsp_rdata, {16'b0, fv(15'h100), fv(15'h101)});
    access(32'h00FF8104, 2'd2, 0, 1, 0);
    chk("R3 long read", rsp_rdata, {fv(15'h104), fv(15'h105), fv(15'h106), fv(15'h107)});
    access(32'h00FF8103, 2'd0, 0, 1, 0);
    chk("R3 byte read", rsp_rdata, {24'b0, fv(15'h103)});
  endtask

  task automatic t_partial_fault;
    access(32'h00FF8110, 2'd0, 0, 1, 0);
    chk("R4 byte on error granule faults", {31'b0, rsp_fault}, 1);
    access(32'h00FF810F, 2'd1, 0, 1, 0);
    chk("R4 straddling word no fault", {31'b0, rsp_fault}, 0);
    chk("R4 error lane reads FF", rsp_rdata, {16'b0, fv(15'h10F), 8'hFF});
    access(32'h00FF8118, 2'd2, 0, 1, 0);
    chk("R4 long all error faults", {31'b0, rsp_fault}, 1);
  endtask

  task automatic t_holes;
    access(32'h00FF8120, 2'd0, 0, 1, 0);
    chk("R5 hole reads FF", rsp_rdata, 32'h0000_00FF);
    chk("R5 hole no fault", {31'b0, rsp_fault}, 0);
    access(32'h00FF8130, 2'd1, 0, 1, 0);
    chk("R5 zero hole reads 00", rsp_rdata, 32'h0);
    access(32'h00FF8120, 2'd1, 1, 1, 32'h0000_1234);
    chk("R5 hole write no strobe", {28'b0, s_stb}, 0);
    access(32'h00FF8120, 2'd1, 0, 1, 0);
    chk("R5 hole unchanged after write", rsp_rdata, 32'h0000_FFFF);
  endtask

  task automatic t_mirror;
    access(32'h00FF8812, 2'd0, 0, 1, 0);
    chk("R6 alias offset", {17'b0, s_addr0}, 32'h0802);
    chk("R6 alias no fault", {31'b0, rsp_fault}, 0);
    chk("R6 alias data", rsp_rdata, {24'b0, fv(15'h802)});
  endtask

  task automatic t_illegal;
    access(32'h00FFFFFF, 2'd1, 0, 1, 0);
    chk("R7 word top no strobe", {28'b0, s_stb}, 0);
    chk("R7 word top no fault", {31'b0, rsp_fault}, 0);
    chk("R7 word top data", rsp_rdata, 32'h0000_FFFF);
    access(32'h00FFFFFD, 2'd2, 1, 1, 32'h01020304);
    chk("R7 long top no strobe", {28'b0, s_stb}, 0);
    chk("R7 long top no fault", {31'b0, rsp_fault}, 0);
    access(32'h00FFFFFC, 2'd2, 0, 1, 0);
    chk("R7 long at limit legal", rsp_rdata, {fv(15'h7FFC), fv(15'h7FFD), fv(15'h7FFE), fv(15'h7FFF)});
  endtask

  task automatic t_strobe_once;
    access(32'h00FF8100, 2'd2, 1, 1, 32'hA1B2C3D4);
    chk("R8 long in one granule strobes once", {28'b0, s_stb}, 32'h1);
    chk("R8 write direction", {31'b0, s_we}, 1);
    chk("R3 big-endian lanes", s_wdata, 32'hD4C3B2A1);
    access(32'h00FF814E, 2'd2, 1, 1, 32'h11223344);
    chk("R8 granule change strobes again", {28'b0, s_stb}, 32'h5);
  endtask

  task automatic t_fault_latch;
    access(32'h12FF8110, 2'd0, 1, 1, 0);
    chk("R9 fault on write", {31'b0, rsp_fault}, 1);
    chk("R9 latched addr", flt_addr, 32'h12FF8110);
    chk("R9 latched write", {31'b0, flt_write}, 1);
    access(32'h00FF8100, 2'd0, 0, 1, 0);
    chk("R9 held after good access", flt_addr, 32'h12FF8110);
    access(32'h00000010, 2'd0, 0, 1, 0);
    chk("R9 latched read", {31'b0, flt_write}, 0);
  endtask

  task automatic t_timing;
    access(32'h00FF8100, 2'd0, 0, 1, 0);
    chk("R10 valid one cycle later", {31'b0, rsp_valid}, 1);
    @(posedge clk); #1;
    chk("R10 valid drops", {31'b0, rsp_valid}, 0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    t_reset();
    t_config();
    t_privilege();
    t_lanes();
    t_partial_fault();
    t_holes();
    t_mirror();
    t_illegal();
    t_strobe_once();
    t_fault_latch();
    t_timing();
    finish_run();
  end
endmodule